// File: doc/BRIEF.md
# Serial Command Dispatcher for a Challenge Mixer and Byte Memory

This block sits behind a byte-wide serial receiver and transmitter. It reads one opcode byte from a host, collects any argument bytes that follow, and then drives one of two resources. The first resource is a challenge mixer, which takes a start pulse and a challenge word and later returns a done pulse with a short response. The second is a byte memory, which the block reads through an address and data port. The reply is streamed back one byte at a time over a valid/ready handshake.

Two opcodes are recognised. The dump opcode reads the whole memory in ascending address order and then sends two fixed trailer bytes. The challenge opcode takes four bytes, builds a 32-bit challenge, starts the mixer, and returns the mixer's response as a single byte. Any other opcode is discarded. The block accepts no input while a reply is outstanding.

Top module: `cmd_dispatch`

## Requirements
- R1: While reset is asserted and right after it is released, tx_valid and mix_start are low and rx_ready is high.
- R2: Opcode 0x01 has no arguments. It returns the memory bytes for addresses 0 up to 2^ADDR_W-1 in increasing order. The memory read is combinational: mem_data reflects mem_addr in the same cycle.
- R3: After the last memory byte of a dump, the block sends 0xAA and then 0x55, so it sends 2^ADDR_W+2 bytes in total. It then returns to waiting for an opcode.
- R4: Opcode 0x04 is followed by exactly four argument bytes, assembled most-significant byte first: the first argument lands in bits 31:24 of mix_challenge. mix_start is high for exactly one cycle, in the cycle after the last argument byte is accepted.
- R5: The reply to 0x04 is exactly one byte. Its low nibble holds the mix_resp value captured on mix_done, and its high nibble is zero.
- R6: Once tx_valid is raised, tx_valid and tx_data stay unchanged until tx_ready is seen. Exactly one byte is consumed per handshake.
- R7: An opcode other than 0x01 or 0x04 is dropped. It produces no reply byte and no mix_start, and rx_ready stays high.
- R8: rx_ready is high only while the block waits for an opcode or collects argument bytes. It is low from the acceptance of a complete command until the last reply byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block can take a received byte |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter takes the reply byte |
| mix_start | output | 1 | One-cycle start pulse to the mixer |
| mix_challenge | output | 8*CHAL_BYTES | Assembled challenge word |
| mix_done | input | 1 | Mixer result valid |
| mix_resp | input | RESP_W | Mixer response bits |
| mem_addr | output | ADDR_W | Memory read address |
| mem_data | input | 8 | Memory read data, combinational |

## Verification
The bench keeps the default parameters: ADDR_W of 8, four challenge bytes and a four-bit response. A full dump therefore covers all 256 addresses, includes the wrap of the low address bits into the trailer, and sends 258 bytes under random transmitter stalls. Keeping the four-byte challenge lets the bench's mixer model use a response function that depends on byte order, so an argument assembled in the wrong order shows up as a wrong reply byte.

// File: rtl/cmd_dispatch.sv
module cmd_dispatch #(
  parameter int ADDR_W = 8,
  parameter int CHAL_BYTES = 4,
  parameter int RESP_W = 4,
  parameter logic [7:0] OP_DUMP = 8'h01,
  parameter logic [7:0] OP_CHAL = 8'h04,
  parameter logic [7:0] TRAIL_A = 8'hAA,
  parameter logic [7:0] TRAIL_B = 8'h55
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  output logic                    rx_ready,
  output logic                    tx_valid,
  output logic [7:0]              tx_data,
  input  logic                    tx_ready,
  output logic                    mix_start,
  output logic [8*CHAL_BYTES-1:0] mix_challenge,
  input  logic                    mix_done,
  input  logic [RESP_W-1:0]       mix_resp,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic [7:0]              mem_data
);
  localparam int CHAL_W = 8 * CHAL_BYTES;
  localparam logic [ADDR_W:0] LAST_IDX = (ADDR_W+1)'((1 << ADDR_W) + 1);
  localparam logic [ADDR_W:0] ARG_LAST = (ADDR_W+1)'(CHAL_BYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_ARG, S_START, S_WAIT, S_RESP, S_DUMP} state_t;

  state_t state;
  logic [ADDR_W:0] cnt;
  logic [CHAL_W-1:0] chal_q;
  logic [RESP_W-1:0] resp_q;

  wire rx_hs = rx_valid && rx_ready;
  wire tx_hs = tx_valid && tx_ready;

  assign rx_ready = (state == S_IDLE) || (state == S_ARG);
  assign tx_valid = (state == S_RESP) || (state == S_DUMP);
  assign mix_start = (state == S_START);
  assign mix_challenge = chal_q;
  assign mem_addr = cnt[ADDR_W-1:0];
  assign tx_data = (state == S_RESP) ? {{(8-RESP_W){1'b0}}, resp_q} :
                   !cnt[ADDR_W]      ? mem_data :
                   cnt[0]            ? TRAIL_B : TRAIL_A;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      chal_q <= '0;
      resp_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (rx_hs) begin
          cnt <= '0;
          if (rx_data == OP_DUMP) state <= S_DUMP;
          else if (rx_data == OP_CHAL) state <= S_ARG;
        end
        S_ARG: if (rx_hs) begin
          chal_q <= {chal_q[CHAL_W-9:0], rx_data};
          cnt    <= cnt + 1'b1;
          if (cnt == ARG_LAST) state <= S_START;
        end
        S_START: state <= S_WAIT;
        S_WAIT: if (mix_done) begin
          resp_q <= mix_resp;
          state  <= S_RESP;
        end
        S_RESP: if (tx_hs) state <= S_IDLE;
        S_DUMP: if (tx_hs) begin
          if (cnt == LAST_IDX) state <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(mem_addr)));
  a_r5_resp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RESP && !tx_ready) |=> $stable(tx_data));
  a_r8_no_rx_while_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);
  a_r4_start_after_arg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mix_start) |-> $past(rx_valid && rx_ready));
  a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mix_start |=> !mix_start);
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && state == S_DUMP && !cnt[ADDR_W])
      |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));
  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && rx_valid && rx_data != OP_DUMP && rx_data != OP_CHAL)
      |=> (state == S_IDLE && !tx_valid));
endmodule

// File: tb/tb_cmd_dispatch.sv
module tb_cmd_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int WATCHDOG = 100000;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_ready;
  logic [7:0] rx_data = 0;
  logic tx_valid, tx_ready;
  logic [7:0] tx_data;
  logic mix_start, mix_done;
  logic [31:0] mix_challenge;
  logic [3:0] mix_resp;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_data;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_data = 8'(mem_addr * 7 + 3);

  cmd_dispatch #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .mix_start(mix_start), .mix_challenge(mix_challenge), .mix_done(mix_done), .mix_resp(mix_resp),
    .mem_addr(mem_addr), .mem_data(mem_data));

  int n_cmp = 0, n_bad = 0, n_start = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [31:0] got_chal = 0;
  bit stall_mode = 0;
  bit held = 0;
  logic [7:0] held_d = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] mixf(logic [31:0] c);
    return c[31:28] ^ c[11:8] ^ {c[2:0], c[3]} ^ 4'h6;
  endfunction

  initial begin
    tx_ready = 0;
    forever begin
      @(posedge clk); #2;
      tx_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  initial begin
    mix_done = 0; mix_resp = 4'hF;
    forever begin
      @(negedge clk);
      if (mix_start) begin
        got_chal = mix_challenge;
        n_start++;
        @(negedge clk); @(negedge clk);
        mix_resp = mixf(got_chal); mix_done = 1;
        @(negedge clk);
        mix_done = 0; mix_resp = 4'hF;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (held) check(tx_valid && tx_data == held_d, "R6 hold", {23'd0, tx_valid, tx_data}, {24'd1, held_d});
      held = tx_valid && !tx_ready;
      held_d = tx_data;
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) check(0, "R7 unexpected reply byte", tx_data, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(tx_data == e, t, tx_data, e);
        end
      end
    end
  end

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    rx_data = b; rx_valid = 1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_dump();
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      exp_q.push_back(8'(a * 7 + 3)); tag_q.push_back("R2 dump byte");
    end
    exp_q.push_back(8'hAA); tag_q.push_back("R3 trailer first");
    exp_q.push_back(8'h55); tag_q.push_back("R3 trailer second");
    send_byte(8'h01);
    check(!rx_ready, "R8 busy after dump opcode", rx_ready, 0);
    wait_idle();
    check(rx_ready, "R3 back to idle", rx_ready, 1);
  endtask

  task automatic do_chal(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3);
    logic [31:0] c;
    c = {b0, b1, b2, b3};
    exp_q.push_back({4'h0, mixf(c)}); tag_q.push_back("R5 challenge reply");
    send_byte(8'h04);
    send_byte(b0); send_byte(b1); send_byte(b2); send_byte(b3);
    check(mix_start, "R4 start pulse timing", mix_start, 1);
    check(!rx_ready, "R8 busy during challenge", rx_ready, 0);
    wait_idle();
    check(got_chal == c, "R4 challenge order", got_chal, c);
  endtask

  task automatic do_bad(logic [7:0] op);
    int s;
    s = n_start;
    send_byte(op);
    repeat (6) @(negedge clk);
    check(rx_ready, "R7 still idle", rx_ready, 1);
    check(n_start == s, "R7 no start", n_start, s);
    check(!tx_valid, "R7 no reply", tx_valid, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!tx_valid && !mix_start, "R1 outputs in reset", {tx_valid, mix_start}, 0);
    rst_n = 1;
    @(negedge clk);
    check(rx_ready && !tx_valid, "R1 after reset", {rx_ready, tx_valid}, 2'b10);
    do_chal(8'h12, 8'h34, 8'h56, 8'h78);
    do_chal(8'hF0, 8'h00, 8'h0F, 8'hA5);
    do_bad(8'h33);
    do_bad(8'h00);
    do_bad(8'hFF);
    do_dump();
    stall_mode = 1;
    do_dump();
    do_chal(8'h80, 8'h01, 8'hC3, 8'h3C);
    do_bad(8'h02);
    do_chal(8'h01, 8'h02, 8'h03, 8'h0E);
    stall_mode = 0;
    check(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule